// File: doc/BRIEF.md
# Out-of-Order-Retire Register Hazard Tracker

This block is the dependency scoreboard for a vector unit that issues instructions in program order but lets them complete in any order. For every architectural vector register it remembers which in-flight instructions still read it (one bit per instruction ID) and which instruction last wrote it. When a new instruction is presented with its ID, up to three source registers and an optional destination, the block returns, in the same cycle, a hazard vector with one bit per ID. Each set bit names an outstanding instruction the new one must wait for.

A writer waits for every reader of its destination that is still running, not only the most recent one. This matters because a slow early reader can still be reading after a fast later reader has finished. Readers wait for the last running writer of each source. Readers never wait for other readers. Successive writers of one register are ordered through the last-writer link.

The caller supplies the instruction IDs and a per-cycle vector of which IDs are still running. Entries belonging to IDs that have stopped running drop out on their own.

Top module: `ooo_hazard_tracker`

## Requirements
- R1: After reset the tables are empty. An instruction issued first gets an all-zero hazard vector, whatever `running_i` holds.
- R2: For each valid source register whose last writer is still running, the hazard vector sets the bit at that writer's ID (read after write).
- R3: When the destination is valid, the hazard vector includes every running instruction that was issued earlier with that register as a valid source, including readers that were issued before a later reader that has already retired (write after read).
- R4: A source register gives no hazard bit for earlier readers of the same register.
- R5: When the destination is valid, the hazard vector sets the bit of that register's last writer if it is still running. Only the most recent writer is kept per register (write after write).
- R6: Hazard bits are only ever set for IDs whose `running_i` bit is 1 in the issue cycle. Entries of IDs that stop running are dropped.
- R7: Retire masking is applied before the issue update within a cycle. An ID whose `running_i` bit is 0 in the cycle it is reissued keeps its new entries afterwards.
- R8: A source slot whose bit in `src_valid_i` is 0 is ignored. It neither adds hazard bits nor records a reader.
- R9: The hazard vector never has the issuing instruction's own ID set, even when a register is both its source and destination.
- R10: While `issue_valid_i` is 0, `hazard_o` is all zero and the tables receive no new entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An instruction is issued this cycle |
| issue_id_i | input | 3 | ID of the issued instruction |
| src_valid_i | input | 3 | Per-slot source valid, bit s for slot s |
| src_reg_i | input | 15 | Source registers, slot s at bits [5s+4:5s] |
| dst_valid_i | input | 1 | The instruction writes a register |
| dst_reg_i | input | 5 | Destination register |
| running_i | input | 8 | Bit i is 1 while instruction ID i is in flight |
| hazard_o | output | 8 | Bit i set: the issued instruction depends on ID i |

## Verification
Several properties are checked on every cycle:
- the hazard vector is silent when nothing is issued;
- it never names the issuer itself;
- it never names a non-running ID;
- back-to-back issue of a writer then a reader (and of a reader then a writer) of the same register links the two.

Dependencies that span many cycles can only be shown by the bench scenarios. These include the slow-reader-overtaken case, ID reuse in the cycle of retirement, last-writer replacement and ignored source slots. The bench covers them with directed sequences and a long random run against a reference model.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned DEF_NUM_IDS  = 8;
  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_NUM_SRC  = 3;
endpackage

// File: rtl/hzd_reader_table.sv
module hzd_reader_table #(
  parameter int unsigned NUM_IDS  = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                issue_valid_i,
  input  logic [NUM_IDS-1:0]                  id_oh_i,
  input  logic [NUM_SRC-1:0]                  src_valid_i,
  input  logic [NUM_SRC*REG_W-1:0]            src_reg_i,
  input  logic [NUM_IDS-1:0]                  running_i,
  output logic [NUM_REGS-1:0][NUM_IDS-1:0]    mask_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic                hit;
    logic [NUM_IDS-1:0]  mask_q;

    always_comb begin
      hit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (issue_valid_i && src_valid_i[s] && src_reg_i[s*REG_W +: REG_W] == REG_W'(r))
          hit = 1'b1;
    end

    // retire masking first, then the new reader
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= (mask_q & running_i) | (hit ? id_oh_i : '0);
    end

    assign mask_o[r] = mask_q;
  end
endmodule

// File: rtl/hzd_writer_table.sv
module hzd_writer_table #(
  parameter int unsigned NUM_IDS  = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ID_W     = $clog2(NUM_IDS),
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             issue_valid_i,
  input  logic [ID_W-1:0]                  issue_id_i,
  input  logic                             dst_valid_i,
  input  logic [REG_W-1:0]                 dst_reg_i,
  input  logic [NUM_IDS-1:0]               running_i,
  output logic [NUM_REGS-1:0]              live_o,
  output logic [NUM_REGS-1:0][ID_W-1:0]    wid_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic            vld_q;
    logic [ID_W-1:0] id_q;
    logic            wr;

    assign wr = issue_valid_i && dst_valid_i && dst_reg_i == REG_W'(r);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        id_q  <= '0;
      end else if (wr) begin
        vld_q <= 1'b1;
        id_q  <= issue_id_i;
      end else if (vld_q && !running_i[id_q]) begin
        vld_q <= 1'b0;
      end
    end

    assign live_o[r] = vld_q && running_i[id_q];
    assign wid_o[r]  = id_q;
  end
endmodule

// File: rtl/hzd_hazard_gen.sv
module hzd_hazard_gen #(
  parameter int unsigned NUM_IDS  = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned ID_W     = $clog2(NUM_IDS),
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                             issue_valid_i,
  input  logic [NUM_IDS-1:0]               id_oh_i,
  input  logic [NUM_SRC-1:0]               src_valid_i,
  input  logic [NUM_SRC*REG_W-1:0]         src_reg_i,
  input  logic                             dst_valid_i,
  input  logic [REG_W-1:0]                 dst_reg_i,
  input  logic [NUM_IDS-1:0]               running_i,
  input  logic [NUM_REGS-1:0][NUM_IDS-1:0] rd_mask_i,
  input  logic [NUM_REGS-1:0]              live_i,
  input  logic [NUM_REGS-1:0][ID_W-1:0]    wid_i,
  output logic [NUM_IDS-1:0]               hazard_o
);
  logic [NUM_IDS-1:0] haz;

  always_comb begin
    haz = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_valid_i[s] && live_i[src_reg_i[s*REG_W +: REG_W]])
        haz[wid_i[src_reg_i[s*REG_W +: REG_W]]] = 1'b1;
    if (dst_valid_i) begin
      haz = haz | (rd_mask_i[dst_reg_i] & running_i);
      if (live_i[dst_reg_i]) haz[wid_i[dst_reg_i]] = 1'b1;
    end
    hazard_o = issue_valid_i ? (haz & ~id_oh_i) : '0;
  end
endmodule

// File: rtl/ooo_hazard_tracker.sv
module ooo_hazard_tracker
  import hzd_pkg::*;
#(
  parameter int unsigned NUM_IDS  = DEF_NUM_IDS,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
  localparam int unsigned ID_W    = $clog2(NUM_IDS),
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_valid_i,
  input  logic [ID_W-1:0]          issue_id_i,
  input  logic [NUM_SRC-1:0]       src_valid_i,
  input  logic [NUM_SRC*REG_W-1:0] src_reg_i,
  input  logic                     dst_valid_i,
  input  logic [REG_W-1:0]         dst_reg_i,
  input  logic [NUM_IDS-1:0]       running_i,
  output logic [NUM_IDS-1:0]       hazard_o
);
  logic [NUM_IDS-1:0]               id_oh;
  logic [NUM_REGS-1:0][NUM_IDS-1:0] rd_mask;
  logic [NUM_REGS-1:0]              live;
  logic [NUM_REGS-1:0][ID_W-1:0]    wid;

  assign id_oh = NUM_IDS'(1) << issue_id_i;

  hzd_reader_table #(
    .NUM_IDS(NUM_IDS), .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .REG_W(REG_W)
  ) u_rd (
    .clk_i, .rst_ni, .issue_valid_i,
    .id_oh_i(id_oh), .src_valid_i, .src_reg_i, .running_i,
    .mask_o(rd_mask)
  );

  hzd_writer_table #(
    .NUM_IDS(NUM_IDS), .NUM_REGS(NUM_REGS), .ID_W(ID_W), .REG_W(REG_W)
  ) u_wr (
    .clk_i, .rst_ni, .issue_valid_i, .issue_id_i, .dst_valid_i, .dst_reg_i,
    .running_i, .live_o(live), .wid_o(wid)
  );

  hzd_hazard_gen #(
    .NUM_IDS(NUM_IDS), .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .ID_W(ID_W), .REG_W(REG_W)
  ) u_gen (
    .issue_valid_i, .id_oh_i(id_oh), .src_valid_i, .src_reg_i,
    .dst_valid_i, .dst_reg_i, .running_i,
    .rd_mask_i(rd_mask), .live_i(live), .wid_i(wid), .hazard_o
  );
endmodule

// File: rtl/ooo_hazard_tracker_chk.sv
module ooo_hazard_tracker_chk #(
  parameter int unsigned NUM_IDS  = 8,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ID_W    = $clog2(NUM_IDS),
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               issue_valid_i,
  input logic [ID_W-1:0]    issue_id_i,
  input logic               src0_valid_i,
  input logic [REG_W-1:0]   src0_reg_i,
  input logic               dst_valid_i,
  input logic [REG_W-1:0]   dst_reg_i,
  input logic [NUM_IDS-1:0] running_i,
  input logic [NUM_IDS-1:0] hazard_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i |-> hazard_o == '0);  // R10

  AST_NO_SELF_DEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> !hazard_o[issue_id_i]);  // R9

  AST_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hazard_o & ~running_i) == '0);  // R6

  AST_RAW_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && dst_valid_i |=>
      (!(issue_valid_i && src0_valid_i && src0_reg_i == $past(dst_reg_i) &&
         issue_id_i != $past(issue_id_i) && running_i[$past(issue_id_i)]) ||
       hazard_o[$past(issue_id_i)]));  // R2

  AST_WAR_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && src0_valid_i |=>
      (!(issue_valid_i && dst_valid_i && dst_reg_i == $past(src0_reg_i) &&
         issue_id_i != $past(issue_id_i) && running_i[$past(issue_id_i)]) ||
       hazard_o[$past(issue_id_i)]));  // R3
endmodule

bind ooo_hazard_tracker ooo_hazard_tracker_chk #(
  .NUM_IDS(NUM_IDS), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i), .issue_id_i(issue_id_i),
  .src0_valid_i(src_valid_i[0]), .src0_reg_i(src_reg_i[REG_W-1:0]),
  .dst_valid_i(dst_valid_i), .dst_reg_i(dst_reg_i), .running_i(running_i),
  .hazard_o(hazard_o)
);

// File: tb/ooo_hazard_tracker_bench.sv
`timescale 1ns/1ps
module ooo_hazard_tracker_bench;
  localparam int CLK_NS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic [2:0]  issue_id_i = '0;
  logic [2:0]  src_valid_i = '0;
  logic [14:0] src_reg_i = '0;
  logic        dst_valid_i = 1'b0;
  logic [4:0]  dst_reg_i = '0;
  logic [7:0]  running_i = '0;
  logic [7:0]  hazard_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] run = '0;
  logic [7:0] m_rd [32];
  bit         m_wv [32];
  int         m_wid[32];

  always #(CLK_NS/2) clk_i = ~clk_i;

  ooo_hazard_tracker u_ooo_hazard_tracker (.*);

  function automatic logic [7:0] exp_hazard(bit v, int id, logic [2:0] sv, int s0, int s1, int s2,
                                            bit dv, int d, logic [7:0] rn);
    logic [7:0] h = '0;
    int srcs[3] = '{s0, s1, s2};
    if (!v) return '0;
    for (int s = 0; s < 3; s++)
      if (sv[s] && m_wv[srcs[s]] && rn[m_wid[srcs[s]]]) h[m_wid[srcs[s]]] = 1'b1;
    if (dv) begin
      h |= m_rd[d] & rn;
      if (m_wv[d] && rn[m_wid[d]]) h[m_wid[d]] = 1'b1;
    end
    h[id] = 1'b0;
    return h;
  endfunction

  task automatic model_update(bit v, int id, logic [2:0] sv, int s0, int s1, int s2,
                              bit dv, int d, logic [7:0] rn);
    int srcs[3] = '{s0, s1, s2};
    for (int r = 0; r < 32; r++) begin
      m_rd[r] &= rn;
      if (m_wv[r] && !rn[m_wid[r]]) m_wv[r] = 0;
    end
    if (v) begin
      for (int s = 0; s < 3; s++)
        if (sv[s]) m_rd[srcs[s]][id] = 1'b1;
      if (dv) begin
        m_wv[d] = 1;
        m_wid[d] = id;
      end
    end
  endtask

  task automatic step(bit v, int id, logic [2:0] sv, int s0, int s1, int s2,
                      bit dv, int d, string tag);
    logic [7:0] e;
    logic [7:0] rn;
    @(negedge clk_i);
    rn = run;
    running_i     = rn;
    issue_valid_i = v;
    issue_id_i    = 3'(id);
    src_valid_i   = sv;
    src_reg_i     = {5'(s2), 5'(s1), 5'(s0)};
    dst_valid_i   = dv;
    dst_reg_i     = 5'(d);
    #1;
    e = exp_hazard(v, id, sv, s0, s1, s2, dv, d, rn);
    checks++;
    if (hazard_o !== e) begin
      errors++;
      $display("FAIL %s: hazard actual=%b expected=%b (id=%0d)", tag, hazard_o, e, id);
    end
    model_update(v, id, sv, s0, s1, s2, dv, d, rn);
    if (v) run[id] = 1'b1;
  endtask

  task automatic idle();
    step(0, 0, 3'b000, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d3c));
    for (int r = 0; r < 32; r++) begin m_rd[r] = '0; m_wv[r] = 0; m_wid[r] = 0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: empty tables, everything marked running
    run = 8'hFF;
    step(1, 0, 3'b001, 1, 0, 0, 1, 1, "R1");
    run = '0;
    for (int r = 0; r < 32; r++) begin m_rd[r] = '0; m_wv[r] = 0; end
    idle(); idle();

    // R2: reader after writer
    step(1, 0, 3'b000, 0, 0, 0, 1, 1, "R2");
    step(1, 1, 3'b001, 1, 0, 0, 0, 0, "R2");
    // R10: no issue while sources point at a live writer
    step(0, 2, 3'b111, 1, 1, 1, 1, 1, "R10");
    // R8: slot 0 names v1 but is invalid
    step(1, 2, 3'b110, 1, 20, 21, 0, 0, "R8");
    // R3 + R5: writer of v1 waits for reader id1 and writer id0, not id2
    step(1, 3, 3'b000, 0, 0, 0, 1, 1, "R3_R5");
    // R4: reader of v1 waits only for writer id3, not reader id1
    step(1, 4, 3'b001, 1, 0, 0, 0, 0, "R4");
    run = '0; idle(); idle();

    // R3: slow reader overtaken by fast reader
    step(1, 5, 3'b011, 4, 2, 0, 1, 6, "R3");
    step(1, 6, 3'b011, 2, 2, 0, 1, 8, "R3");
    step(1, 7, 3'b011, 12, 12, 0, 1, 2, "R3");  // expects ids 5,6
    run[6] = 1'b0;                              // fast reader retires
    step(1, 0, 3'b001, 12, 0, 0, 1, 2, "R3_R6"); // expects ids 5,7
    run = '0; idle(); idle();

    // R9: issuer still flagged running, source == destination
    step(1, 3, 3'b001, 5, 0, 0, 1, 5, "R9");
    step(1, 3, 3'b001, 5, 0, 0, 1, 5, "R9");
    // R7: id3 retires and is reissued in the same cycle
    run[3] = 1'b0;
    step(1, 3, 3'b000, 0, 0, 0, 1, 5, "R7");
    step(1, 4, 3'b001, 5, 0, 0, 0, 0, "R7");    // expects id3
    run = '0; idle(); idle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int id;
      for (int k = 0; k < 8; k++)
        if (run[k] && ($urandom % 4 == 0)) run[k] = 1'b0;
      id = -1;
      if (run != 8'hFF && ($urandom % 4 != 0)) begin
        do id = $urandom % 8; while (run[id]);
      end
      if (id < 0) idle();
      else step(1, id, 3'($urandom), $urandom % 8, $urandom % 8, $urandom % 8,
                1'($urandom), $urandom % 8, "R2_R3_R5_R6");
    end

    finish_run();
  end
endmodule